// File: doc/BRIEF.md
# Timer Channel Capture/Match Unit

This block is one channel of a timer array, tied to a single pin whose direction is set by a controlling engine. It watches two free-running 16-bit timebases. It can record the time of an input edge on the pin, and it can fire a one-shot match when a chosen timebase reaches or passes a programmed value. The match also drives a programmed action onto the pin.

The engine sets up the channel with a configuration write. That write chooses the pin direction and the initial output level. It also picks which timebase feeds the comparator and which one feeds the capture register, the capture edge and the pin action. A separate write loads the match value and arms the comparator. The channel reports each capture and each match with a single-cycle event pulse. Every channel in an array is an identical copy of this block.

Top module: `tmr_channel`

## Requirements
- R1: After reset, pin_oe, pin_out, cap_val, cap_evt and match_evt are all zero, the comparator is disarmed, capture is off and the pin action is "keep".
- R2: A cycle with cfg_we high loads the direction, the timebase selects, the edge mode, the pin action and the pin level at the next clock edge. pin_oe then equals cfg_dir_out and pin_out equals cfg_pin_lvl. Without cfg_we, pin_oe does not change.
- R3: While armed, the comparator treats the selected timebase as reached when (timebase − match value) mod 65536 has bit 15 clear. This covers differences 0 through 0x7FFF. match_evt goes high at the first clock edge after a cycle in which that holds.
- R4: A match fires once. The edge that raises match_evt disarms the comparator, so match_evt is never high for two cycles in a row. No further match occurs until match_we is asserted again.
- R5: cfg_match_sel picks the timebase for matching (0 = tb_a, 1 = tb_b). The timebase that is not selected has no effect on matching.
- R6: The pin action code takes effect on the same clock edge that raises match_evt: 00 keeps the pin, 01 drives it high, 10 drives it low and 11 toggles it. pin_out changes only on a match or after a configuration write.
- R7: pin_in passes through two synchronizer flops before edge detection. The edge code sets which edges capture: 00 none, 01 rising, 10 falling, 11 both. On the third rising clock edge after a qualifying pin change, cap_val loads the timebase chosen by cfg_cap_sel (0 = tb_a, 1 = tb_b) and cap_evt pulses for one cycle. At all other times cap_val holds its value.
- R8: Pin edges are ignored while the direction is output. Neither cap_evt nor cap_val reacts to them.
- R9: A match_we whose value the selected timebase has already reached makes the match fire at the next clock edge. A match_we in the same cycle as a pending fire takes precedence and re-arms the comparator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tb_a | input | 16 | First timebase value |
| tb_b | input | 16 | Second timebase value |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_dir_out | input | 1 | Direction: 1 = output, 0 = input |
| cfg_match_sel | input | 1 | Timebase for matching (0 = tb_a) |
| cfg_cap_sel | input | 1 | Timebase for capture (0 = tb_a) |
| cfg_edge | input | 2 | Capture edge code |
| cfg_action | input | 2 | Pin action code on match |
| cfg_pin_lvl | input | 1 | Output level loaded by a configuration write |
| match_we | input | 1 | Load match value and arm |
| match_val | input | 16 | Match value |
| pin_in | input | 1 | Pin level as seen from outside |
| pin_out | output | 1 | Level driven onto the pin |
| pin_oe | output | 1 | Output enable for the pin |
| cap_val | output | 16 | Last captured timebase value |
| cap_evt | output | 1 | One-cycle capture event |
| match_evt | output | 1 | One-cycle match event |

## Verification
The assertions rely on three assumptions about the inputs. Configuration and match writes are single-cycle strobes. pin_in is held low through reset. Each timebase changes only between clock edges, so it is stable at the edge where it is sampled. The bench drives every input just after a falling clock edge and keeps each pin level for at least three cycles, so no edge is lost in the synchronizer. It approaches the comparator's half-range boundary from both sides and places only one write in any cycle where a match could fire.

// File: rtl/tc_pkg.sv
package tc_pkg;

    typedef enum logic [1:0] {
        EDGE_OFF  = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_ANY  = 2'b11
    } edge_mode_e;

    typedef enum logic [1:0] {
        ACT_KEEP   = 2'b00,
        ACT_HIGH   = 2'b01,
        ACT_LOW    = 2'b10,
        ACT_TOGGLE = 2'b11
    } pin_act_e;

endpackage

// File: rtl/tc_pin_sync.sv
module tc_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise,
    output logic fall
);
    localparam int CHAIN_W = STAGES + 1;

    logic [CHAIN_W-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[CHAIN_W-2:0], pin};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    // newest synchronized sample against the one before it
    assign rise = chain_q[STAGES-1] & ~chain_q[STAGES];
    assign fall = ~chain_q[STAGES-1] & chain_q[STAGES];
endmodule

// File: rtl/tc_tb_pick.sv
module tc_tb_pick #(
    parameter int TB_W = 16
) (
    input  logic            sel,
    input  logic [TB_W-1:0] tb_a,
    input  logic [TB_W-1:0] tb_b,
    output logic [TB_W-1:0] tb_out
);
    assign tb_out = sel ? tb_b : tb_a;
endmodule

// File: rtl/tc_ge_cmp.sv
module tc_ge_cmp #(
    parameter int TB_W = 16
) (
    input  logic [TB_W-1:0] now_val,
    input  logic [TB_W-1:0] ref_val,
    output logic            reached
);
    localparam int SIGN_BIT = TB_W - 1;

    logic [TB_W-1:0] diff;

    // half-range window: the difference lies in [0, 2^(W-1))
    assign diff    = now_val - ref_val;
    assign reached = ~diff[SIGN_BIT];
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tc_pkg::*;
#(
    parameter int TB_W        = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [TB_W-1:0] tb_a,
    input  logic [TB_W-1:0] tb_b,
    input  logic            cfg_we,
    input  logic            cfg_dir_out,
    input  logic            cfg_match_sel,
    input  logic            cfg_cap_sel,
    input  logic [1:0]      cfg_edge,
    input  logic [1:0]      cfg_action,
    input  logic            cfg_pin_lvl,
    input  logic            match_we,
    input  logic [TB_W-1:0] match_val,
    input  logic            pin_in,
    output logic            pin_out,
    output logic            pin_oe,
    output logic [TB_W-1:0] cap_val,
    output logic            cap_evt,
    output logic            match_evt
);

    typedef struct packed {
        logic            dir_out;
        logic            match_sel;
        logic            cap_sel;
        edge_mode_e      edge_mode;
        pin_act_e        pin_act;
        logic            pin_lvl;
        logic            armed;
        logic [TB_W-1:0] match_reg;
        logic [TB_W-1:0] cap_reg;
        logic            match_pulse;
        logic            cap_pulse;
    } chan_st_t;

    localparam chan_st_t ST_RESET = '0;

    chan_st_t st_d, st_q;

    logic            pin_rise, pin_fall;
    logic [TB_W-1:0] tb_for_match, tb_for_cap;
    logic            reached;
    logic            fire, cap_hit;

    tc_pin_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .pin  (pin_in),
        .rise (pin_rise),
        .fall (pin_fall)
    );

    tc_tb_pick #(.TB_W(TB_W)) i_pick_match (
        .sel   (st_q.match_sel),
        .tb_a  (tb_a),
        .tb_b  (tb_b),
        .tb_out(tb_for_match)
    );

    tc_tb_pick #(.TB_W(TB_W)) i_pick_cap (
        .sel   (st_q.cap_sel),
        .tb_a  (tb_a),
        .tb_b  (tb_b),
        .tb_out(tb_for_cap)
    );

    tc_ge_cmp #(.TB_W(TB_W)) i_cmp (
        .now_val(tb_for_match),
        .ref_val(st_q.match_reg),
        .reached(reached)
    );

    assign fire    = st_q.armed & reached;
    assign cap_hit = ~st_q.dir_out &
                     ((pin_rise & st_q.edge_mode[0]) | (pin_fall & st_q.edge_mode[1]));

    always_comb begin
        st_d             = st_q;
        st_d.match_pulse = 1'b0;
        st_d.cap_pulse   = 1'b0;

        if (fire) begin
            st_d.match_pulse = 1'b1;
            st_d.armed       = 1'b0;
            unique case (st_q.pin_act)
                ACT_HIGH:   st_d.pin_lvl = 1'b1;
                ACT_LOW:    st_d.pin_lvl = 1'b0;
                ACT_TOGGLE: st_d.pin_lvl = ~st_q.pin_lvl;
                default:    st_d.pin_lvl = st_q.pin_lvl;
            endcase
        end

        if (cfg_we) begin
            st_d.dir_out   = cfg_dir_out;
            st_d.match_sel = cfg_match_sel;
            st_d.cap_sel   = cfg_cap_sel;
            st_d.edge_mode = edge_mode_e'(cfg_edge);
            st_d.pin_act   = pin_act_e'(cfg_action);
            st_d.pin_lvl   = cfg_pin_lvl;
        end

        if (match_we) begin
            st_d.match_reg   = match_val;
            st_d.armed       = 1'b1;
            st_d.match_pulse = 1'b0;
        end

        if (cap_hit) begin
            st_d.cap_reg   = tb_for_cap;
            st_d.cap_pulse = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_RESET;
        else        st_q <= st_d;
    end

    assign pin_out   = st_q.pin_lvl;
    assign pin_oe    = st_q.dir_out;
    assign cap_val   = st_q.cap_reg;
    assign cap_evt   = st_q.cap_pulse;
    assign match_evt = st_q.match_pulse;

endmodule

// File: rtl/tmr_channel_chk.sv
module tmr_channel_chk #(
    parameter int TB_W = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cfg_we,
    input logic            pin_oe,
    input logic            pin_out,
    input logic [TB_W-1:0] cap_val,
    input logic            cap_evt,
    input logic            match_evt
);

    assert_match_oneshot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        match_evt |=> !match_evt);

    assert_cap_only_input_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cap_evt |-> !$past(pin_oe));

    assert_dir_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cfg_we) |-> $stable(pin_oe));

    assert_pin_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pin_out) |-> (match_evt || $past(cfg_we)));

    assert_cap_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_evt |-> $stable(cap_val));

endmodule

bind tmr_channel tmr_channel_chk #(.TB_W(TB_W)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .pin_oe   (pin_oe),
    .pin_out  (pin_out),
    .cap_val  (cap_val),
    .cap_evt  (cap_evt),
    .match_evt(match_evt)
);

// File: tb/test_tmr_channel.sv
module test_tmr_channel;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] tb_a = '0, tb_b = '0;
    logic        cfg_we = 1'b0, cfg_dir_out = 1'b0, cfg_match_sel = 1'b0;
    logic        cfg_cap_sel = 1'b0, cfg_pin_lvl = 1'b0;
    logic [1:0]  cfg_edge = '0, cfg_action = '0;
    logic        match_we = 1'b0;
    logic [15:0] match_val = '0;
    logic        pin_in = 1'b0;
    logic        pin_out, pin_oe, cap_evt, match_evt;
    logic [15:0] cap_val;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    tmr_channel i_tmr_channel (
        .clk(clk), .rst_n(rst_n), .tb_a(tb_a), .tb_b(tb_b),
        .cfg_we(cfg_we), .cfg_dir_out(cfg_dir_out), .cfg_match_sel(cfg_match_sel),
        .cfg_cap_sel(cfg_cap_sel), .cfg_edge(cfg_edge), .cfg_action(cfg_action),
        .cfg_pin_lvl(cfg_pin_lvl), .match_we(match_we), .match_val(match_val),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .cap_val(cap_val),
        .cap_evt(cap_evt), .match_evt(match_evt)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic cfg(input logic dir, input logic msel, input logic csel,
                       input logic [1:0] edg, input logic [1:0] act, input logic lvl);
        cfg_we = 1'b1; cfg_dir_out = dir; cfg_match_sel = msel; cfg_cap_sel = csel;
        cfg_edge = edg; cfg_action = act; cfg_pin_lvl = lvl;
        step();
        cfg_we = 1'b0;
    endtask

    task automatic arm(input logic [15:0] v);
        match_we = 1'b1; match_val = v;
        step();
        match_we = 1'b0;
    endtask

    task automatic t_reset;
        check("R1 pin_oe", {15'd0, pin_oe}, 16'd0);
        check("R1 pin_out", {15'd0, pin_out}, 16'd0);
        check("R1 cap_val", cap_val, 16'd0);
        check("R1 events", {14'd0, cap_evt, match_evt}, 16'd0);
        tb_a = 16'h0100;
        step(2);
        check("R1 no match while disarmed", {15'd0, match_evt}, 16'd0);
    endtask

    task automatic t_config;
        cfg(1'b1, 1'b0, 1'b0, 2'b01, 2'b01, 1'b1);
        check("R2 pin_oe follows cfg", {15'd0, pin_oe}, 16'd1);
        check("R2 pin_out follows cfg", {15'd0, pin_out}, 16'd1);
        cfg(1'b1, 1'b0, 1'b0, 2'b01, 2'b01, 1'b0);
        check("R2 level reload", {15'd0, pin_out}, 16'd0);
    endtask

    task automatic t_match_basic;
        tb_a = 16'd100;
        arm(16'd200);
        step();
        check("R3 below target", {15'd0, match_evt}, 16'd0);
        tb_a = 16'd199;
        step();
        check("R3 one below", {15'd0, match_evt}, 16'd0);
        tb_a = 16'd200;
        step();
        check("R3 equal fires", {15'd0, match_evt}, 16'd1);
        check("R6 action high", {15'd0, pin_out}, 16'd1);
        step();
        check("R4 single pulse", {15'd0, match_evt}, 16'd0);
        tb_a = 16'd300;
        step(2);
        check("R4 stays disarmed", {15'd0, match_evt}, 16'd0);
        arm(16'd250);
        step();
        check("R9 past-due fires", {15'd0, match_evt}, 16'd1);
    endtask

    task automatic t_wrap;
        cfg(1'b1, 1'b0, 1'b0, 2'b00, 2'b11, 1'b0);
        tb_a = 16'h0005;
        arm(16'hFFF0);
        step();
        check("R3 wrap fires", {15'd0, match_evt}, 16'd1);
        check("R6 toggle up", {15'd0, pin_out}, 16'd1);
        tb_a = 16'h8010;
        arm(16'h0010);
        step();
        check("R3 diff 0x8000 no fire", {15'd0, match_evt}, 16'd0);
        tb_a = 16'h800F;
        step();
        check("R3 diff 0x7FFF fires", {15'd0, match_evt}, 16'd1);
        check("R6 toggle down", {15'd0, pin_out}, 16'd0);
    endtask

    task automatic t_sel;
        cfg(1'b1, 1'b1, 1'b0, 2'b00, 2'b10, 1'b1);
        tb_a = 16'h5000; tb_b = 16'h0100;
        arm(16'h1000);
        step();
        check("R5 tb_a ignored", {15'd0, match_evt}, 16'd0);
        tb_b = 16'h1000;
        step();
        check("R5 tb_b fires", {15'd0, match_evt}, 16'd1);
        check("R6 action low", {15'd0, pin_out}, 16'd0);
        cfg(1'b1, 1'b0, 1'b0, 2'b00, 2'b00, 1'b1);
        tb_a = 16'd10;
        arm(16'd5);
        step();
        check("R6 keep fires", {15'd0, match_evt}, 16'd1);
        check("R6 keep level", {15'd0, pin_out}, 16'd1);
    endtask

    task automatic t_capture;
        cfg(1'b0, 1'b0, 1'b1, 2'b01, 2'b00, 1'b0);
        check("R2 input dir", {15'd0, pin_oe}, 16'd0);
        tb_a = 16'h0AAA; tb_b = 16'h1234;
        pin_in = 1'b1;
        step();
        check("R7 sync stage 1", {15'd0, cap_evt}, 16'd0);
        step();
        check("R7 sync stage 2", {15'd0, cap_evt}, 16'd0);
        step();
        check("R7 rising capture", {15'd0, cap_evt}, 16'd1);
        check("R7 captured tb_b", cap_val, 16'h1234);
        step();
        check("R7 pulse ends", {15'd0, cap_evt}, 16'd0);
        tb_b = 16'h2222;
        pin_in = 1'b0;
        for (int i = 0; i < 4; i++) begin
            step();
            check("R7 falling ignored in rise mode", {15'd0, cap_evt}, 16'd0);
        end
        check("R7 value held", cap_val, 16'h1234);
        cfg(1'b0, 1'b0, 1'b0, 2'b10, 2'b00, 1'b0);
        tb_a = 16'h0BBB;
        pin_in = 1'b1;
        step(4);
        check("R7 rising ignored in fall mode", cap_val, 16'h1234);
        pin_in = 1'b0;
        step(3);
        check("R7 falling capture", {15'd0, cap_evt}, 16'd1);
        check("R7 captured tb_a", cap_val, 16'h0BBB);
        cfg(1'b0, 1'b0, 1'b0, 2'b11, 2'b00, 1'b0);
        tb_a = 16'h0C0C;
        pin_in = 1'b1;
        step(3);
        check("R7 any mode rise", cap_val, 16'h0C0C);
        tb_a = 16'h0D0D;
        pin_in = 1'b0;
        step(3);
        check("R7 any mode fall", cap_val, 16'h0D0D);
        step();
    endtask

    task automatic t_output_ignores_pin;
        cfg(1'b1, 1'b0, 1'b0, 2'b11, 2'b00, 1'b0);
        tb_a = 16'h7777;
        pin_in = 1'b1;
        for (int i = 0; i < 4; i++) begin
            step();
            check("R8 no capture when output", {15'd0, cap_evt}, 16'd0);
        end
        pin_in = 1'b0;
        step(4);
        check("R8 value untouched", cap_val, 16'h0D0D);
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        step();
        t_reset();
        t_config();
        t_match_basic();
        t_wrap();
        t_sel();
        t_capture();
        t_output_ignores_pin();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog all-requirements actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule